// File: doc/BRIEF.md
# On-the-fly AES Round-Key Generator

This block turns an AES cipher key of 128, 192 or 256 bits into the full stream of round-key words. It produces one 32-bit word per clock, so it can feed a column-serial encryption datapath without any precomputed key storage. A `start` pulse selects the key size and begins a run. The cipher key then arrives as 32-bit words, one per cycle that has `kin_valid` set. Each key word is echoed on the output straight away, so the datapath can start its first rounds while the upper part of a long key is still loading. Once the last key word is in, the block derives every further schedule word from a sliding window of earlier words. The result goes to the output and is also written back into the window.

The window consists of two banks of four 32-bit stages. The first bank always shifts. The second bank is held in 128-bit mode, half of it shifts in 192-bit mode, and all of it shifts in 256-bit mode. The older operand is tapped from a stage that depends on the key size. A transform unit with four S-boxes applies the rotation, the substitution and the round constant only on the cycles the schedule calls for. On every other cycle its S-box inputs sit at a constant mask.

Top module: `aes_key_sched`

## Requirements
- R1: After reset, `rk_valid` is 0 and stays 0 until key words are accepted after a `start`.
- R2: `ksize` is sampled on a cycle with `start` high, with the encoding 2'b00 = 128-bit, 2'b01 = 192-bit, 2'b10 = 256-bit; 2'b11 behaves as 128-bit. `rk_valid` is 0 in the cycle after `start`. A `start` during a run abandons it: no further words of the old run appear.
- R3: While loading, every cycle with `kin_valid` high accepts `kin_word` as the next key word (first word is w0, byte 0 in bits 31:24). That word appears on `rk_word` with `rk_valid` high one cycle later. Loading ends after Nk = 4, 6 or 8 words.
- R4: Starting from the cycle after the last key word is output, one new word is output every cycle with no gap, until 44, 52 or 60 words have been output in total. After that, `rk_valid` stays 0.
- R5: For i ≥ Nk, word i equals w[i−Nk] XOR t. Here t is w[i−1], except when i mod Nk = 0: then t is SubWord of w[i−1] rotated left by one byte (bits 31:24 move to 7:0), XORed with {rcon,8'h00,8'h00,8'h00}.
- R6: rcon follows 01,02,04,08,10,20,40,80,1B,36. It advances once per rotating transform and restarts at 01 on every `start`.
- R7: In 256-bit mode, when i mod 8 = 4, t is SubWord(w[i−1]) with no rotation and no constant.
- R8: Whenever no transform is applied (idle, loading, plain cycles), the S-box inputs hold a constant mask. In 128-bit mode the second window bank does not shift.
- R9: `kin_valid` and `kin_word` are ignored when the block is idle or generating.
- R10: During loading, a cycle with `kin_valid` low accepts nothing and produces no output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new key schedule, sampling `ksize` |
| ksize | input | 2 | Key size code |
| kin_valid | input | 1 | `kin_word` carries a key word |
| kin_word | input | 32 | Cipher key word, w0 first |
| rk_valid | output | 1 | `rk_word` carries a schedule word |
| rk_word | output | 32 | Round-key word stream |

## Verification
Three kinds of cycle can collide here. Key loading can meet the generation stream. A stray key word can meet generation. A restart can meet an unfinished schedule. The bench drives `kin_valid` with junk words during generation and requires the output stream to stay word-exact. It also issues a `start` in the middle of a 128-bit schedule and requires the stream to switch cleanly to the new 256-bit key: one silent cycle, then no leftover word from the old run. A scoreboard holds the words of an independently computed key schedule, checked against published known answers, and compares them against every output word.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

    typedef enum logic [1:0] {
        KS_128 = 2'd0,
        KS_192 = 2'd1,
        KS_256 = 2'd2
    } ks_size_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_GEN  = 2'd2
    } ks_phase_e;

    typedef struct packed {
        ks_phase_e   phase;
        ks_size_e    size;
        logic [5:0]  widx;   // words emitted so far in this run
        logic [2:0]  ph;     // word index modulo Nk
        logic [3:0]  ridx;   // round-constant index
        logic        valid;
        logic [31:0] word;
    } ks_state_t;

    function automatic ks_size_e ks_decode(input logic [1:0] code);
        case (code)
            2'd1:    return KS_192;
            2'd2:    return KS_256;
            default: return KS_128;
        endcase
    endfunction

    // Nk - 1 for each key size
    function automatic logic [2:0] nk_last(input ks_size_e s);
        case (s)
            KS_192:  return 3'd5;
            KS_256:  return 3'd7;
            default: return 3'd3;
        endcase
    endfunction

    // total schedule words - 1 (4 * (Nk + 7) - 1)
    function automatic logic [5:0] word_last(input ks_size_e s);
        case (s)
            KS_192:  return 6'd51;
            KS_256:  return 6'd59;
            default: return 6'd43;
        endcase
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] x;
        acc = 8'h00;
        x   = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254 (0 maps to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        r = 8'h01;
        p = a;
        for (int k = 1; k < 8; k++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] sbox_fn(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [7:0] rcon_of(input logic [3:0] idx);
        case (idx)
            4'd0: return 8'h01;
            4'd1: return 8'h02;
            4'd2: return 8'h04;
            4'd3: return 8'h08;
            4'd4: return 8'h10;
            4'd5: return 8'h20;
            4'd6: return 8'h40;
            4'd7: return 8'h80;
            4'd8: return 8'h1b;
            4'd9: return 8'h36;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/aes_ks_sbox.sv
module aes_ks_sbox
    import aes_ks_pkg::*;
(
    input  logic [7:0] sb_in,
    output logic [7:0] sb_out
);
    assign sb_out = sbox_fn(sb_in);
endmodule

// File: rtl/aes_ks_xform.sv
module aes_ks_xform
    import aes_ks_pkg::*;
#(
    parameter logic [7:0] SBOX_MASK = 8'h00,
    parameter int         LANES     = 4
) (
    input  logic [8*LANES-1:0] last_word,
    input  logic               rot_en,
    input  logic               sub_en,
    input  logic [3:0]         rcon_idx,
    output logic [8*LANES-1:0] xf_word,
    output logic [8*LANES-1:0] sb_in
);
    localparam int W = 8 * LANES;

    logic [W-1:0] rotated;
    logic [W-1:0] sb_out;

    // byte rotation is wiring only
    assign rotated = {last_word[W-9:0], last_word[W-1:W-8]};

    // inputs held at the mask whenever the schedule needs no substitution
    assign sb_in = rot_en ? rotated : (sub_en ? last_word : {LANES{SBOX_MASK}});

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        aes_ks_sbox u_sb (
            .sb_in (sb_in[8*g +: 8]),
            .sb_out(sb_out[8*g +: 8])
        );
    end

    // the constant only touches the top byte
    assign xf_word = {sb_out[W-1:W-8] ^ (rot_en ? rcon_of(rcon_idx) : 8'h00),
                      sb_out[W-9:0]};
endmodule

// File: rtl/aes_ks_window.sv
module aes_ks_window
    import aes_ks_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  ks_size_e          size,
    output logic [WORD_W-1:0] newest,
    output logic [WORD_W-1:0] tap,
    output logic              bank_b_en
);
    localparam int HALF = STAGES / 2;

    logic [WORD_W-1:0] a_q [STAGES];
    logic [WORD_W-1:0] a_d [STAGES];
    logic [WORD_W-1:0] b_q [STAGES];
    logic [WORD_W-1:0] b_d [STAGES];
    logic [STAGES-1:0] b_stage_en;

    always_comb begin
        bank_b_en = push && (size != KS_128);
        for (int s = 0; s < STAGES; s++) begin
            b_stage_en[s] = bank_b_en && ((size == KS_256) || (s < HALF));
        end
        a_d = a_q;
        b_d = b_q;
        if (push) begin
            a_d[0] = push_word;
            for (int s = 1; s < STAGES; s++) a_d[s] = a_q[s-1];
        end
        if (b_stage_en[0]) b_d[0] = a_q[STAGES-1];
        for (int s = 1; s < STAGES; s++) begin
            if (b_stage_en[s]) b_d[s] = b_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                a_q[s] <= '0;
                b_q[s] <= '0;
            end
        end else begin
            a_q <= a_d;
            b_q <= b_d;
        end
    end

    assign newest = a_q[0];

    always_comb begin
        case (size)
            KS_192:  tap = b_q[HALF-1];
            KS_256:  tap = b_q[STAGES-1];
            default: tap = a_q[STAGES-1];
        endcase
    end
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
    import aes_ks_pkg::*;
#(
    parameter logic [7:0] SBOX_MASK = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  ksize,
    input  logic        kin_valid,
    input  logic [31:0] kin_word,
    output logic        rk_valid,
    output logic [31:0] rk_word
);
    localparam int LANES  = 4;
    localparam int WORD_W = 8 * LANES;
    localparam int STAGES = 4;
    localparam ks_state_t ST_RESET = '{PH_IDLE, KS_128, 6'd0, 3'd0, 4'd0, 1'b0, 32'd0};

    ks_state_t         st_q, st_d;
    logic              push;
    logic [WORD_W-1:0] push_word, gen_word;
    logic [WORD_W-1:0] newest, tap, xf_word, sb_in;
    logic              rot_en, sub_en, sb_act, bank_b_en;
    logic              loading, generating;

    aes_ks_window #(.STAGES(STAGES), .WORD_W(WORD_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_word(push_word),
        .size     (st_q.size),
        .newest   (newest),
        .tap      (tap),
        .bank_b_en(bank_b_en)
    );

    aes_ks_xform #(.SBOX_MASK(SBOX_MASK), .LANES(LANES)) u_xf (
        .last_word(newest),
        .rot_en   (rot_en),
        .sub_en   (sub_en),
        .rcon_idx (st_q.ridx),
        .xf_word  (xf_word),
        .sb_in    (sb_in)
    );

    assign loading    = (st_q.phase == PH_LOAD);
    assign generating = (st_q.phase == PH_GEN);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        rot_en     = generating && (st_q.ph == 3'd0);
        sub_en     = generating && (st_q.size == KS_256) && (st_q.ph == 3'd4);
        sb_act     = rot_en || sub_en;
        gen_word   = tap ^ (sb_act ? xf_word : newest);
        push       = 1'b0;
        push_word  = gen_word;

        if (start) begin
            st_d.phase = PH_LOAD;
            st_d.size  = ks_decode(ksize);
            st_d.widx  = 6'd0;
            st_d.ph    = 3'd0;
            st_d.ridx  = 4'd0;
        end else if (loading) begin
            if (kin_valid) begin
                push      = 1'b1;
                push_word = kin_word;
            end
        end else if (generating) begin
            push = 1'b1;
        end

        if (push) begin
            st_d.valid = 1'b1;
            st_d.word  = push_word;
            st_d.widx  = st_q.widx + 6'd1;
            st_d.ph    = (st_q.ph == nk_last(st_q.size)) ? 3'd0 : st_q.ph + 3'd1;
            if (loading && (st_q.ph == nk_last(st_q.size))) st_d.phase = PH_GEN;
            if (generating && (st_q.widx == word_last(st_q.size))) st_d.phase = PH_IDLE;
            if (rot_en) st_d.ridx = st_q.ridx + 4'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign rk_valid = st_q.valid;
    assign rk_word  = st_q.word;
endmodule

// File: rtl/aes_key_sched_chk.sv
module aes_key_sched_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        kin_valid,
    input logic [31:0] kin_word,
    input logic        rk_valid,
    input logic [31:0] rk_word,
    input logic        loading,
    input logic        generating,
    input logic        rot_en,
    input logic        sb_act,
    input logic [31:0] sb_in,
    input logic        bank_b_en,
    input logic [1:0]  size_q,
    input logic [3:0]  ridx
);
    assert_start_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !rk_valid);

    assert_load_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && kin_valid && !start) |=> (rk_valid && rk_word == $past(kin_word)));

    assert_gen_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (generating && !start) |=> rk_valid);

    assert_idle_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!loading && !generating && !start) |=> !rk_valid);

    assert_load_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && !kin_valid && !start) |=> !rk_valid);

    assert_rcon_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rot_en |-> (ridx <= 4'd9));

    assert_sbox_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sb_act && $past(!sb_act)) |-> $stable(sb_in));

    assert_bank_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == 2'd0) |-> !bank_b_en);
endmodule

bind aes_key_sched aes_key_sched_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .kin_valid (kin_valid),
    .kin_word  (kin_word),
    .rk_valid  (rk_valid),
    .rk_word   (rk_word),
    .loading   (loading),
    .generating(generating),
    .rot_en    (rot_en),
    .sb_act    (sb_act),
    .sb_in     (sb_in),
    .bank_b_en (bank_b_en),
    .size_q    (st_q.size),
    .ridx      (st_q.ridx)
);

// File: tb/sim_aes_key_sched.sv
`timescale 1ns/1ps
module sim_aes_key_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  ksize = 2'd0;
    logic        kin_valid = 1'b0;
    logic [31:0] kin_word = 32'd0;
    logic        rk_valid;
    logic [31:0] rk_word;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;
    string cur_tag = "R1";

    logic [31:0] exp_q [$];
    logic [7:0]  inv_t [256];
    logic [31:0] ref_w [60];

    always #10 clk = ~clk;

    aes_key_sched u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ksize(ksize),
        .kin_valid(kin_valid), .kin_word(kin_word),
        .rk_valid(rk_valid), .rk_word(rk_word)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = 16'h0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] bsub(input logic [7:0] x);
        logic [7:0] v, s;
        logic [7:0] c;
        v = inv_t[x];
        c = 8'h63;
        for (int i = 0; i < 8; i++)
            s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
        return s;
    endfunction

    function automatic logic [31:0] bsubw(input logic [31:0] w);
        return {bsub(w[31:24]), bsub(w[23:16]), bsub(w[15:8]), bsub(w[7:0])};
    endfunction

    task automatic build_ref(input int nk, input logic [31:0] k [8]);
        logic [7:0]  rc;
        logic [31:0] t;
        rc = 8'h01;
        for (int i = 0; i < nk; i++) ref_w[i] = k[i];
        for (int i = nk; i < 4 * (nk + 7); i++) begin
            t = ref_w[i-1];
            if (i % nk == 0) begin
                t  = bsubw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = bmul(rc, 8'h02);
            end else if (nk == 8 && i % 8 == 4) begin
                t = bsubw(t);
            end
            ref_w[i] = ref_w[i-nk] ^ t;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // ---------------- monitor (scoreboard) ----------------
    always @(negedge clk) begin
        if (rst_n && rk_valid && !finished) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL %s: unexpected word got %h expected none", cur_tag, rk_word);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (rk_word !== e) begin
                    n_fail++;
                    $display("FAIL %s: word got %h expected %h", cur_tag, rk_word, e);
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- driver ----------------
    task automatic begin_key(input logic [1:0] code, input int nk, input logic [31:0] k [8],
                             input bit gaps, input bit stray, input bit flush, input string tag);
        build_ref(nk, k);
        @(negedge clk);
        start = 1'b1;
        ksize = code;
        kin_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        cur_tag = tag;
        check("R2 silent after start", {31'd0, rk_valid}, 32'd0);
        if (flush) exp_q.delete();
        for (int i = 0; i < 4 * (nk + 7); i++) exp_q.push_back(ref_w[i]);
        for (int j = 0; j < nk; j++) begin
            if (gaps && (j % 2 == 1)) begin
                kin_valid = 1'b0;
                kin_word  = 32'hdead0000 + 32'(j);   // R10: not a key word
                @(negedge clk);
            end
            kin_valid = 1'b1;
            kin_word  = k[j];
            @(negedge clk);
        end
        kin_valid = 1'b0;
        if (stray) begin
            for (int j = 0; j < 5; j++) begin        // R9: junk during generation
                kin_valid = 1'b1;
                kin_word  = 32'hbad0beef ^ 32'(j);
                @(negedge clk);
            end
            kin_valid = 1'b0;
        end
    endtask

    task automatic drain(input string tag);
        int guard;
        guard = 0;
        while (exp_q.size() > 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check({tag, " words left"}, 32'(exp_q.size()), 32'd0);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check("R4 quiet after last word", {31'd0, rk_valid}, 32'd0);
        end
    endtask

    logic [31:0] k128 [8];
    logic [31:0] k192 [8];
    logic [31:0] k256 [8];
    logic [31:0] kalt [8];

    initial begin
        for (int a = 0; a < 256; a++) inv_t[a] = 8'h00;
        for (int a = 1; a < 256; a++)
            for (int b = 1; b < 256; b++)
                if (bmul(8'(a), 8'(b)) == 8'h01) inv_t[a] = 8'(b);

        k128 = '{32'h2b7e1516, 32'h28aed2a6, 32'habf71588, 32'h09cf4f3c, 0, 0, 0, 0};
        k192 = '{32'h8e73b0f7, 32'hda0e6452, 32'hc810f32b, 32'h809079e5,
                 32'h62f8ead2, 32'h522c6b7b, 0, 0};
        k256 = '{32'h603deb10, 32'h15ca71be, 32'h2b73aef0, 32'h857d7781,
                 32'h1f352c07, 32'h3b6108d7, 32'h2d9810a3, 32'h0914dff4};
        kalt = '{32'h00010203, 32'h04050607, 32'h08090a0b, 32'h0c0d0e0f, 0, 0, 0, 0};

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, rk_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, rk_valid}, 32'd0);

        // R9: junk while idle
        for (int j = 0; j < 4; j++) begin
            kin_valid = 1'b1;
            kin_word  = 32'h12345678 + 32'(j);
            @(negedge clk);
            check("R9 idle word ignored", {31'd0, rk_valid}, 32'd0);
        end
        kin_valid = 1'b0;

        // model known answers (R5 R6 R7)
        build_ref(4, k128);
        check("R5 R6 model w4", ref_w[4], 32'ha0fafe17);
        check("R5 R6 model w43", ref_w[43], 32'hb6630ca6);
        build_ref(6, k192);
        check("R5 model w51", ref_w[51], 32'h01002202);
        build_ref(8, k256);
        check("R7 model w59", ref_w[59], 32'h706c631e);

        // 128-bit contiguous load
        begin_key(2'b00, 4, k128, 1'b0, 1'b0, 1'b0, "R3 R4 R5 R6 R8 128");
        drain("R4 128");

        // 192-bit with load gaps
        begin_key(2'b01, 6, k192, 1'b1, 1'b0, 1'b0, "R3 R5 R10 192 gaps");
        drain("R10 192");

        // 256-bit with stray words during generation
        begin_key(2'b10, 8, k256, 1'b0, 1'b1, 1'b0, "R7 R9 256 stray");
        drain("R9 256");

        // unused size code acts as 128
        begin_key(2'b11, 4, kalt, 1'b0, 1'b0, 1'b0, "R2 code 11");
        drain("R2 code 11");

        // restart in the middle of a 128-bit run
        begin_key(2'b00, 4, kalt, 1'b0, 1'b0, 1'b0, "R2 first run");
        repeat (8) @(negedge clk);
        begin_key(2'b10, 8, k256, 1'b1, 1'b1, 1'b1, "R2 R6 restart 256");
        drain("R2 restart");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule